// File: doc/BRIEF.md
# Fuse Array Byte Read Sequencer

This block reads a run of bytes out of a one-time-programmable fuse array. A client hands it a starting byte offset and a byte count in one cycle, while the block signals that it is idle. The block then walks the fuse macro through a fixed pin protocol:

- a preamble with load and program-disable asserted;
- for each byte, an address setup gap, a strobe pulse, a sample of the macro's 8-bit data output, and a release gap;
- a final return to the low-power standby pin state.

Every gap is timed in clock cycles from a parameter giving the number of clock cycles per microsecond. Each protocol step lasts exactly one such microsecond.

The macro pins are presented as one packed control word so that a neighbouring wrapper can decode fixed bit positions. Each sampled byte comes back as a one-cycle valid pulse with its data. A one-cycle completion pulse marks the end of a transfer. Programming the fuses, gating the clock and any bus wrapper belong to other blocks.

Top module: `efuse_byte_reader`

## Requirements
- R1: In reset and whenever idle, the control word equals 0x009. In that word, bit 0 is chip-select-bar and bit 3 is program-enable-bar, both high. Bit 1 is strobe and bit 2 is load, both low, and the address field in bits 15:6 is zero. While idle, `req_ready` is high and `rd_valid` and `xfer_done` are low.
- R2: After a request with a non-zero count is accepted, the control word is 0x00C (load and program-enable-bar high, chip-select-bar low) for exactly CYCLES_PER_US cycles.
- R3: For byte i of a transfer, the control word is first 0x00C with address field (offset + i) mod 1024 and strobe low, for CYCLES_PER_US cycles.
- R4: After that setup gap, strobe (bit 1) is high for exactly CYCLES_PER_US cycles, with the address unchanged.
- R5: In the first cycle after strobe falls, `rd_valid` is high for one cycle. `rd_data` then equals the fuse data output as it was in the last strobe-high cycle.
- R6: After strobe falls, the address is held with strobe low for CYCLES_PER_US cycles. Then the next byte's setup starts at the next address. The address wraps from 1023 to 0.
- R7: After the release gap of the last byte, the control word returns to 0x009. `xfer_done` is high for exactly that first standby cycle.
- R8: `req_ready` is low from acceptance until standby is re-entered. A request presented while busy is ignored: it neither changes the running transfer nor starts another one afterwards.
- R9: A request with a count of zero leaves the block in standby. It raises no strobe, no `rd_valid` and no `xfer_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_offset | input | 10 | First fuse byte address |
| req_count | input | COUNT_W | Number of bytes to read |
| req_ready | output | 1 | High only in standby; request accepted when both are high |
| fuse_ctrl | output | 16 | Macro pins: bit0 chip-select-bar, bit1 strobe, bit2 load, bit3 program-enable-bar, bits 15:6 address |
| fuse_dout | input | 8 | Data output of the fuse macro |
| rd_valid | output | 1 | One-cycle pulse per sampled byte |
| rd_data | output | 8 | Sampled byte |
| xfer_done | output | 1 | One-cycle pulse on return to standby after a transfer |

## Verification
A wrong phase or a miscounted gap shows on the control word in the very cycle it goes astray. This is because the bench predicts the full pin pattern for every cycle of a transfer from the offset, the count and the gap length. A stale or unadvanced address shows as a wrong address field at the next setup gap. A wrong sample instant shows as a mismatching byte on the valid pulse, because the bench's fuse model only drives data while strobe is high. A lost byte count shows as an early or missing completion pulse, or as ready returning at the wrong cycle.

// File: rtl/efrd_pkg.sv
// Shared definitions for the fuse byte read sequencer.
// Assumes a 10-bit fuse byte address and a 16-bit packed pin word.
package efrd_pkg;

    localparam int ADDR_W   = 10;
    localparam int DATA_W   = 8;
    localparam int CTRL_W   = 16;

    // Pin positions inside the control word; a neighbour decodes these.
    localparam int BIT_CSB  = 0;
    localparam int BIT_STRB = 1;
    localparam int BIT_LOAD = 2;
    localparam int BIT_PGNB = 3;
    localparam int ADDR_LSB = 6;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_PRE   = 3'd1,
        PH_SETUP = 3'd2,
        PH_STRB  = 3'd3,
        PH_REL   = 3'd4
    } phase_t;

    // Builds the packed pin word for a phase and address.
    function automatic logic [CTRL_W-1:0] pin_word(phase_t ph, logic [ADDR_W-1:0] a);
        logic [CTRL_W-1:0] w;
        w = '0;
        if (ph == PH_IDLE) begin
            w[BIT_CSB]  = 1'b1;
            w[BIT_PGNB] = 1'b1;
        end else begin
            w[BIT_LOAD] = 1'b1;
            w[BIT_PGNB] = 1'b1;
            w[BIT_STRB] = (ph == PH_STRB);
            if (ph != PH_PRE) w[ADDR_LSB +: ADDR_W] = a;
        end
        return w;
    endfunction

endpackage

// File: rtl/efrd_gap_timer.sv
// Gap timer: counts one timed gap of GAP_CYCLES clock cycles.
// Assumes reload is pulsed on the clock edge where a new phase begins;
// expired is high in the last cycle of the gap.
module efrd_gap_timer #(
    parameter int GAP_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    output logic expired
);
    localparam int CNT_W = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(GAP_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Reload on phase change, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (reload)       cnt_q <= TOP;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R2 R4: a gap never exceeds the configured length
    gap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);

    // R4: after a reload the counter is at its top value
    gap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt_q == TOP));
endmodule

// File: rtl/efrd_addr_track.sv
// Address and remaining-count tracker for one transfer.
// Assumes load and step are never high together; step only while bytes remain.
module efrd_addr_track #(
    parameter int COUNT_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [efrd_pkg::ADDR_W-1:0] load_addr,
    input  logic [COUNT_W-1:0]         load_count,
    input  logic                       step,
    output logic [efrd_pkg::ADDR_W-1:0] addr,
    output logic                       last
);
    import efrd_pkg::*;

    logic [ADDR_W-1:0]  addr_q;
    logic [COUNT_W-1:0] rem_q;

    // Capture a new transfer or advance one byte; the address wraps at 10 bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else if (load) begin
            addr_q <= load_addr;
            rem_q  <= load_count;
        end else if (step) begin
            addr_q <= addr_q + 1'b1;
            rem_q  <= rem_q - 1'b1;
        end
    end

    assign addr = addr_q;
    assign last = (rem_q == COUNT_W'(1));

    // R6: a step is only taken while a byte is outstanding
    step_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (rem_q != '0));

    // R6: each step moves the address by exactly one, modulo 1024
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (addr_q == $past(addr_q) + 1'b1));
endmodule

// File: rtl/efrd_phase_fsm.sv
// Phase sequencer: preamble, then setup/strobe/release per byte, then standby.
// Assumes the gap timer reports expiry in the last cycle of each phase.
module efrd_phase_fsm (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             zero_count,
    input  logic             gap_expired,
    input  logic             last_byte,
    output efrd_pkg::phase_t phase,
    output logic             gap_reload,
    output logic             addr_load,
    output logic             addr_step,
    output logic             sample,
    output logic             finish
);
    import efrd_pkg::*;

    phase_t phase_q, phase_d;

    // Next-phase and strobe-side decisions for the current cycle.
    always_comb begin
        phase_d    = phase_q;
        gap_reload = 1'b0;
        addr_load  = 1'b0;
        addr_step  = 1'b0;
        sample     = 1'b0;
        finish     = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (start && !zero_count) begin
                    phase_d    = PH_PRE;
                    gap_reload = 1'b1;
                    addr_load  = 1'b1;
                end
            end
            PH_PRE: begin
                if (gap_expired) begin
                    phase_d    = PH_SETUP;
                    gap_reload = 1'b1;
                end
            end
            PH_SETUP: begin
                if (gap_expired) begin
                    phase_d    = PH_STRB;
                    gap_reload = 1'b1;
                end
            end
            PH_STRB: begin
                if (gap_expired) begin
                    phase_d    = PH_REL;
                    gap_reload = 1'b1;
                    sample     = 1'b1;
                end
            end
            PH_REL: begin
                if (gap_expired) begin
                    addr_step = 1'b1;
                    if (last_byte) begin
                        phase_d = PH_IDLE;
                        finish  = 1'b1;
                    end else begin
                        phase_d    = PH_SETUP;
                        gap_reload = 1'b1;
                    end
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    assign phase = phase_q;

    // R4: strobe phase is only entered from address setup
    strb_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_STRB && $past(phase_q) != PH_STRB) |-> ($past(phase_q) == PH_SETUP));

    // R9: a zero-count request never leaves standby
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && start && zero_count) |=> (phase_q == PH_IDLE));
endmodule

// File: rtl/efuse_byte_reader.sv
// Top of the fuse byte read sequencer.
// Accepts {offset,count} in standby, drives the macro pin word, returns bytes.
// Assumes fuse_dout is valid while strobe is high and the gap covers its access time.
module efuse_byte_reader #(
    parameter int CYCLES_PER_US = 50,
    parameter int COUNT_W       = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [9:0]           req_offset,
    input  logic [COUNT_W-1:0]   req_count,
    output logic                 req_ready,
    output logic [15:0]          fuse_ctrl,
    input  logic [7:0]           fuse_dout,
    output logic                 rd_valid,
    output logic [7:0]           rd_data,
    output logic                 xfer_done
);
    import efrd_pkg::*;

    phase_t            phase;
    logic              gap_reload, gap_expired;
    logic              addr_load, addr_step, last_byte;
    logic              sample, finish;
    logic [ADDR_W-1:0] cur_addr;
    logic              valid_q, done_q;
    logic [DATA_W-1:0] data_q;

    efrd_gap_timer #(.GAP_CYCLES(CYCLES_PER_US)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (gap_reload),
        .expired (gap_expired)
    );

    efrd_addr_track #(.COUNT_W(COUNT_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (addr_load),
        .load_addr  (req_offset),
        .load_count (req_count),
        .step       (addr_step),
        .addr       (cur_addr),
        .last       (last_byte)
    );

    efrd_phase_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (req_valid),
        .zero_count  (req_count == '0),
        .gap_expired (gap_expired),
        .last_byte   (last_byte),
        .phase       (phase),
        .gap_reload  (gap_reload),
        .addr_load   (addr_load),
        .addr_step   (addr_step),
        .sample      (sample),
        .finish      (finish)
    );

    // Capture the fuse byte at the end of the strobe and flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            valid_q <= sample;
            done_q  <= finish;
            if (sample) data_q <= fuse_dout;
        end
    end

    assign req_ready = (phase == PH_IDLE);
    assign fuse_ctrl = pin_word(phase, cur_addr);
    assign rd_valid  = valid_q;
    assign rd_data   = data_q;
    assign xfer_done = done_q;

    // R1: whenever ready, the pins are in standby
    ready_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (fuse_ctrl == 16'h0009));

    // R4: address is steady while strobe rises
    strb_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fuse_ctrl[BIT_STRB]) |-> $stable(fuse_ctrl[15:6]));

    // R5: a byte is only presented right after strobe was high
    valid_after_strb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(fuse_ctrl[BIT_STRB]) && !fuse_ctrl[BIT_STRB]));

    // R7: completion pulse lasts one cycle and coincides with standby
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (req_ready && !$past(req_ready)));

    // R8: a busy block holds ready low until it finishes
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(finish)) |=> !req_ready || xfer_done);
endmodule

// File: tb/tb_efuse_byte_reader.sv
module tb_efuse_byte_reader;
    localparam int G   = 3;
    localparam int CW  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [9:0]    req_offset = '0;
    logic [CW-1:0] req_count = '0;
    logic          req_ready;
    logic [15:0]   fuse_ctrl;
    logic [7:0]    fuse_dout;
    logic          rd_valid;
    logic [7:0]    rd_data;
    logic          xfer_done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    efuse_byte_reader #(.CYCLES_PER_US(G), .COUNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
        .req_count(req_count), .req_ready(req_ready), .fuse_ctrl(fuse_ctrl),
        .fuse_dout(fuse_dout), .rd_valid(rd_valid), .rd_data(rd_data),
        .xfer_done(xfer_done)
    );

    // Behavioural fuse array: data only while strobe is high.
    function automatic logic [7:0] fuse_byte(int a);
        return 8'(((a * 29) ^ (a >> 2) ^ 8'h5A) & 8'hFF);
    endfunction
    assign fuse_dout = fuse_ctrl[1] ? fuse_byte(int'(fuse_ctrl[15:6])) : 8'h00;

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected pin word k cycles after the accepting edge.
    function automatic int exp_ctrl(int k, int off, int n);
        int j, i, ph;
        if (k < G) return 'h00C;
        j = k - G;
        if (j >= 3 * G * n) return 'h009;
        i  = j / (3 * G);
        ph = (j % (3 * G)) / G;
        return ((ph == 1) ? 'h00E : 'h00C) | (((off + i) % 1024) << 6);
    endfunction

    function automatic string ctrl_tag(int k, int n);
        int j, ph;
        if (k < G) return "R2";
        j = k - G;
        if (j >= 3 * G * n) return "R7";
        ph = (j % (3 * G)) / G;
        return (ph == 0) ? "R3" : (ph == 1) ? "R4" : "R6";
    endfunction

    task automatic run(int off, int n, bit poke_busy);
        int total;
        @(negedge clk);
        check("R1 ready before request", int'(req_ready), 1);
        check("R1 standby word", int'(fuse_ctrl), 'h009);
        req_valid  = 1'b1;
        req_offset = 10'(off);
        req_count  = CW'(n);
        @(negedge clk);
        req_valid = 1'b0;
        if (n == 0) begin
            for (int k = 0; k < 4 * G; k++) begin
                check("R9 word", int'(fuse_ctrl), 'h009);
                check("R9 valid", int'(rd_valid), 0);
                check("R9 done", int'(xfer_done), 0);
                @(negedge clk);
            end
            return;
        end
        total = G + 3 * G * n + 4;
        for (int k = 0; k < total; k++) begin
            int j = k - G;
            bit ev = (j >= 0) && (j < 3 * G * n) && ((j % (3 * G)) == 2 * G);
            if (poke_busy && (k == G + 1 || k == G + 2)) begin
                req_valid  = 1'b1;
                req_offset = 10'h155;
                req_count  = CW'(3);
            end else begin
                req_valid = 1'b0;
            end
            check(ctrl_tag(k, n), int'(fuse_ctrl), exp_ctrl(k, off, n));
            check("R5 valid", int'(rd_valid), int'(ev));
            if (ev)
                check("R5 data", int'(rd_data), int'(fuse_byte((off + j / (3 * G)) % 1024)));
            check("R7 done", int'(xfer_done), int'(j == 3 * G * n));
            check("R8 ready", int'(req_ready), int'(j >= 3 * G * n));
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    initial begin
        int offs[4] = '{0, 5, 1021, 512};
        repeat (3) @(negedge clk);
        check("R1 reset ready", int'(req_ready), 1);
        check("R1 reset word", int'(fuse_ctrl), 'h009);
        check("R1 reset valid", int'(rd_valid), 0);
        check("R1 reset done", int'(xfer_done), 0);
        rst_n = 1'b1;
        foreach (offs[o]) begin
            for (int n = 0; n <= 5; n++) run(offs[o], n, 1'b0);
        end
        run(1022, 4, 1'b1);   // R6 wrap plus R8 busy request
        run(7, 2, 1'b1);      // R8 busy request ignored
        run(1023, 1, 1'b0);
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule